// File: doc/BRIEF.md
# CAN Bit Timing Unit

This block turns a module clock into CAN bit timing. A programmable prescaler divides the clock into time quanta. Each bit is then built from a one-quantum sync segment, a phase that ends at the sample point, and a phase that runs from the sample point to the end of the bit. Two one-cycle strobes mark the sample point and the transmit point (the start of the sync segment). The unit also captures the bus level at each sample point.

The unit keeps itself aligned to the bus. A hard-sync request, or a falling edge while the unit is waiting for a frame, restarts the bit with no jump-width limit. A recessive-to-dominant edge inside a running bit moves the sample point by at most the programmed jump width. The phase before the sample point is lengthened, or the phase after it is shortened.

A 16-bit configuration word holds the prescaler, the two phase lengths and the jump width. Each field is stored as its value minus one. The word resets to a setting that gives 500 kbit/s from an 8 MHz clock. Software may change it only while both the configuration-enable and init inputs are high.

Top module: `can_bit_timer`

## Requirements
- R1: After reset `cfg_rdata` reads 0x2301. Bit 15 of the word always reads 0. `cfg_rdata` shows the stored word one cycle after an accepted write.
- R2: The layout is: bits 14:12 phase-after length minus one, bits 11:8 phase-before length minus one, bits 7:6 jump width minus one, bits 5:0 prescaler minus one. A write is stored only when `cfg_wr`, `cfg_en` and `init_mode` are all high at the clock edge; otherwise the word is unchanged.
- R3: One time quantum lasts prescaler field + 1 clock cycles, so field values 0..63 give 1..64 cycles.
- R4: With L1 = phase-before field + 1 and L2 = phase-after field + 1, a bit lasts 1 + L1 + L2 quanta. Take E as the edge that ends the phase before the sample point. `sample_pulse` is high for exactly the one cycle after E. `tx_pulse` is high for the one cycle after the edge that ends the phase after the sample point.
- R5: A phase-before field of 0 acts as 1, so that phase is never shorter than two quanta.
- R6: `sampled_bit` resets to 1 (recessive). It takes the `rx` level seen at the sample edge and updates together with `sample_pulse`.
- R7: A hard sync happens at an edge where `init_mode` is low and either `hard_sync_req` is high or the unit is waiting and `rx` falls (1 at the previous edge, 0 at this one). The bit then restarts at the start of the phase before the sample point, and the prescaler restarts. A hard sync overrides any strobe due at the same edge. No resynchronisation follows in the bit a hard sync starts.
- R8: Take a falling `rx` edge seen during quantum index q (counted from 0) of the phase before the sample point. That phase is lengthened by min(q+1, jump width field + 1) quanta.
- R9: Take a falling edge seen during quantum index q of the phase after the sample point. That phase is shortened by min(remaining quanta, jump width field + 1), where the remaining quanta are the phase length minus q. The quantum in progress is always completed.
- R10: At most one resynchronisation is made per bit. Later falling edges in the same bit have no effect.
- R11: A resynchronisation is made only if `sampled_bit` is 1 (recessive) when the edge arrives.
- R12: While `init_mode` is high the unit waits and gives no strobes, and hard-sync requests and edges are ignored. After `init_mode` falls, the unit keeps waiting until a hard sync starts it.
- R13: `sample_pulse` and `tx_pulse` are never high in the same cycle, and no strobe appears except as stated in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write data |
| cfg_en | input | 1 | Configuration-change enable |
| init_mode | input | 1 | Init mode; holds the unit waiting and unlocks writes |
| cfg_rdata | output | 16 | Stored configuration word |
| rx | input | 1 | Bus receive level, 1 = recessive |
| hard_sync_req | input | 1 | Request to hard-synchronise at this edge |
| sample_pulse | output | 1 | One-cycle sample-point strobe |
| tx_pulse | output | 1 | One-cycle transmit-point strobe |
| sampled_bit | output | 1 | Bus level captured at the last sample point |

## Verification
A hard-sync request can arrive at the very edge that ends the phase before the sample point. The bench provokes this by asserting the request at the second sample edge of a running bit. It expects no strobe there, and it expects the next sample and transmit strobes exactly one restarted phase length later. A resynchronising edge can also land in the last quantum of the phase after the sample point, so the shortening ends the bit at the edge where the edge is seen. The bench times a falling edge to do this and checks that `tx_pulse` appears at once and that the following bit keeps its nominal length.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int CFG_W = 16;
  localparam int BRP_W = 6;
  localparam int TS1_W = 4;
  localparam int TS2_W = 3;
  localparam int SJW_W = 2;

  typedef struct packed {
    logic [TS2_W-1:0] ph2;
    logic [TS1_W-1:0] ph1;
    logic [SJW_W-1:0] sjw;
    logic [BRP_W-1:0] brp;
  } bt_cfg_t;

  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SYNC = 2'd1,
    SEG_PH1  = 2'd2,
    SEG_PH2  = 2'd3
  } seg_e;
endpackage

// File: rtl/cbt_cfg_reg.sv
module cbt_cfg_reg #(
  parameter int             W       = 16,
  parameter logic [W-1:0]   RST_VAL = 16'h2301,
  parameter logic [W-1:0]   KEEP    = 16'h7FFF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         cfg_en,
  input  logic         init_mode,
  output logic [W-1:0] cfg_q
);
  logic wr_ok;
  assign wr_ok = wr_en & cfg_en & init_mode;

  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= RST_VAL & KEEP;
    else if (wr_ok) cfg_q <= wr_data & KEEP;
  end

  // R2: the word is locked unless both unlock inputs are high during a write
  assert_locked_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && cfg_en && init_mode) |=> $stable(cfg_q));
endmodule

// File: rtl/cbt_tq_prescaler.sv
module cbt_tq_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clr,
  input  logic [BRP_W-1:0] brp,
  output logic             tick
);
  logic [BRP_W-1:0] cnt;

  assign tick = run && !clr && (cnt == brp);

  always_ff @(posedge clk) begin
    if (rst || !run || clr) cnt <= '0;
    else if (cnt == brp)    cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // R3: a divider above one never ticks on two neighbouring cycles
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && brp != '0) |=> !tick);
endmodule

// File: rtl/cbt_bit_seq.sv
module cbt_bit_seq
  import can_bt_pkg::*;
#(
  parameter int TS1_W = 4,
  parameter int TS2_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_mode,
  input  logic             tick,
  input  logic             rx,
  input  logic             hs_req,
  input  logic [TS1_W-1:0] ph1_f,
  input  logic [TS2_W-1:0] ph2_f,
  input  logic [SJW_W-1:0] sjw_f,
  output logic             hs_evt,
  output logic             sample_pulse,
  output logic             tx_pulse,
  output logic             sampled_bit
);
  localparam int LEN_W = $clog2((1 << TS1_W) + (1 << SJW_W) + 2);

  seg_e             seg_q;
  logic [LEN_W-1:0] qcnt, seg_len, len1, len2, sjw_len;
  logic [LEN_W-1:0] err, adj, eff_len, qnext;
  logic             rx_d, fall, resynced, rs_ok, seg_end;

  assign fall    = rx_d & ~rx;
  assign hs_evt  = !init_mode && (hs_req || (seg_q == SEG_IDLE && fall));
  assign len1    = (ph1_f == '0) ? LEN_W'(2) : LEN_W'(ph1_f) + LEN_W'(1);
  assign len2    = LEN_W'(ph2_f) + LEN_W'(1);
  assign sjw_len = LEN_W'(sjw_f) + LEN_W'(1);
  assign qnext   = qcnt + LEN_W'(1);

  always_comb begin
    rs_ok   = 1'b0;
    err     = '0;
    adj     = '0;
    eff_len = seg_len;
    if (fall && !resynced && sampled_bit) begin
      if (seg_q == SEG_PH1) begin
        rs_ok   = 1'b1;
        err     = qnext;
        adj     = (err > sjw_len) ? sjw_len : err;
        eff_len = seg_len + adj;
      end else if (seg_q == SEG_PH2) begin
        rs_ok   = 1'b1;
        err     = seg_len - qcnt;
        adj     = (err > sjw_len) ? sjw_len : err;
        eff_len = seg_len - adj;
      end
    end
  end

  assign seg_end = tick && (qnext >= eff_len);

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q        <= SEG_IDLE;
      qcnt         <= '0;
      seg_len      <= '0;
      resynced     <= 1'b0;
      rx_d         <= 1'b1;
      sample_pulse <= 1'b0;
      tx_pulse     <= 1'b0;
      sampled_bit  <= 1'b1;
    end else begin
      rx_d         <= rx;
      sample_pulse <= 1'b0;
      tx_pulse     <= 1'b0;
      if (init_mode) begin
        seg_q <= SEG_IDLE;
        qcnt  <= '0;
      end else if (hs_evt) begin
        seg_q    <= SEG_PH1;
        qcnt     <= '0;
        seg_len  <= len1;
        resynced <= 1'b1;
      end else if (seg_q != SEG_IDLE) begin
        if (rs_ok) begin
          resynced <= 1'b1;
          seg_len  <= eff_len;
        end
        if (tick) begin
          if (seg_end) begin
            qcnt <= '0;
            unique case (seg_q)
              SEG_SYNC: begin
                seg_q   <= SEG_PH1;
                seg_len <= len1;
              end
              SEG_PH1: begin
                seg_q        <= SEG_PH2;
                seg_len      <= len2;
                sample_pulse <= 1'b1;
                sampled_bit  <= rx;
              end
              SEG_PH2: begin
                seg_q    <= SEG_SYNC;
                seg_len  <= LEN_W'(1);
                tx_pulse <= 1'b1;
                resynced <= 1'b0;
              end
              default: seg_q <= SEG_IDLE;
            endcase
          end else begin
            qcnt <= qnext;
          end
        end
      end
    end
  end

  // R13: the two strobes never coincide
  assert_single_strobe_R13: assert property (@(posedge clk) disable iff (rst)
    !(sample_pulse && tx_pulse));
  // R12: init silences the unit from the next cycle on
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    init_mode |=> (!sample_pulse && !tx_pulse && seg_q == SEG_IDLE));
  // R7: a hard sync restarts the before-sample phase and suppresses strobes
  assert_hs_restart_R7: assert property (@(posedge clk) disable iff (rst)
    hs_evt |=> (seg_q == SEG_PH1 && qcnt == '0 && !sample_pulse && !tx_pulse));
  // R4: the sync segment is one quantum long
  assert_sync_one_tq_R4: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && !hs_evt && tick && seg_q == SEG_SYNC) |=> seg_q == SEG_PH1);
  // R4: the transmit strobe marks the start of the sync segment
  assert_tx_in_sync_R4: assert property (@(posedge clk) disable iff (rst)
    tx_pulse |-> seg_q == SEG_SYNC);
  // R5: the before-sample phase never ends after its first quantum
  assert_ph1_min_R5: assert property (@(posedge clk) disable iff (rst)
    (!init_mode && tick && seg_q == SEG_PH1 && qcnt == '0) |=> seg_q == SEG_PH1);
endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int               W       = CFG_W,
  parameter logic [W-1:0]     RST_VAL = 16'h2301
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_wr,
  input  logic [W-1:0] cfg_wdata,
  input  logic         cfg_en,
  input  logic         init_mode,
  output logic [W-1:0] cfg_rdata,
  input  logic         rx,
  input  logic         hard_sync_req,
  output logic         sample_pulse,
  output logic         tx_pulse,
  output logic         sampled_bit
);
  localparam logic [W-1:0] KEEP = {1'b0, {(W-1){1'b1}}};

  bt_cfg_t cfg;
  logic    tick, hs_evt;

  cbt_cfg_reg #(.W(W), .RST_VAL(RST_VAL), .KEEP(KEEP)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(cfg_wr), .wr_data(cfg_wdata),
    .cfg_en(cfg_en), .init_mode(init_mode), .cfg_q(cfg_rdata)
  );

  assign cfg = bt_cfg_t'(cfg_rdata[W-2:0]);

  cbt_tq_prescaler #(.BRP_W(BRP_W)) u_tq (
    .clk(clk), .rst(rst), .run(!init_mode), .clr(hs_evt),
    .brp(cfg.brp), .tick(tick)
  );

  cbt_bit_seq #(.TS1_W(TS1_W), .TS2_W(TS2_W), .SJW_W(SJW_W)) u_seq (
    .clk(clk), .rst(rst), .init_mode(init_mode), .tick(tick), .rx(rx),
    .hs_req(hard_sync_req), .ph1_f(cfg.ph1), .ph2_f(cfg.ph2), .sjw_f(cfg.sjw),
    .hs_evt(hs_evt), .sample_pulse(sample_pulse), .tx_pulse(tx_pulse),
    .sampled_bit(sampled_bit)
  );
endmodule

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;
  logic        clk = 1'b0;
  logic        rst, cfg_wr, cfg_en, init_mode, rx, hard_sync_req;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        sample_pulse, tx_pulse, sampled_bit;

  always #10 clk = ~clk;

  can_bit_timer u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_en(cfg_en), .init_mode(init_mode), .cfg_rdata(cfg_rdata),
    .rx(rx), .hard_sync_req(hard_sync_req), .sample_pulse(sample_pulse),
    .tx_pulse(tx_pulse), .sampled_bit(sampled_bit)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    checks = 0, failures = 0, pulses = 0;
  int    exp_s[$];
  int    exp_t[$];
  logic  exp_b[$];
  string s_tag[$];
  string t_tag[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic want_sample(input int c, input logic b, input string t);
    exp_s.push_back(c); exp_b.push_back(b); s_tag.push_back(t);
  endtask

  task automatic want_tx(input int c, input string t);
    exp_t.push_back(c); t_tag.push_back(t);
  endtask

  task automatic step_to(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [15:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  // monitor: pops expected strobe cycles and compares
  always @(negedge clk) begin
    if (!rst) begin
      if (sample_pulse && tx_pulse) chk(1'b0, "R13", "strobes together at cycle", cyc, -1);
      if (sample_pulse) begin
        pulses++;
        if (exp_s.size() == 0) chk(1'b0, "R13", "unexpected sample strobe at cycle", cyc, -1);
        else begin
          int c; logic b; string t;
          c = exp_s.pop_front(); b = exp_b.pop_front(); t = s_tag.pop_front();
          chk(cyc == c, t, "sample strobe cycle", cyc, c);
          chk(sampled_bit == b, "R6", "sampled level", int'(sampled_bit), int'(b));
        end
      end
      if (tx_pulse) begin
        pulses++;
        if (exp_t.size() == 0) chk(1'b0, "R13", "unexpected tx strobe at cycle", cyc, -1);
        else begin
          int c; string t;
          c = exp_t.pop_front(); t = t_tag.pop_front();
          chk(cyc == c, t, "tx strobe cycle", cyc, c);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL R4 watchdog expired actual=%0d expected=finished", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int h, p0;
    rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; cfg_en = 1'b0;
    init_mode = 1'b0; rx = 1'b1; hard_sync_req = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cfg_rdata == 16'h2301, "R1", "reset word", cfg_rdata, 16'h2301);
    chk(!sample_pulse, "R4", "sample strobe after reset", sample_pulse, 0);
    chk(!tx_pulse, "R4", "tx strobe after reset", tx_pulse, 0);
    chk(sampled_bit == 1'b1, "R6", "sampled level after reset", sampled_bit, 1);

    // R2: locked unless both unlock inputs high
    cfg_write(16'h1234);
    chk(cfg_rdata == 16'h2301, "R2", "write with both low", cfg_rdata, 16'h2301);
    init_mode = 1'b1; cfg_write(16'h1234);
    chk(cfg_rdata == 16'h2301, "R2", "write with only init", cfg_rdata, 16'h2301);
    init_mode = 1'b0; cfg_en = 1'b1; cfg_write(16'h1234);
    chk(cfg_rdata == 16'h2301, "R2", "write with only enable", cfg_rdata, 16'h2301);
    cfg_en = 1'b0;
    repeat (4) @(negedge clk);

    // default 500k setting: 2 clocks per quantum, 1+4+3 quanta; hard sync collides with sample
    h = cyc + 1;
    hard_sync_req = 1'b1;
    want_sample(h + 8, 1'b1, "R3");
    want_tx(h + 14, "R4");
    want_sample(h + 32, 1'b1, "R7");
    want_tx(h + 38, "R7");
    @(negedge clk); hard_sync_req = 1'b0;
    step_to(h + 23); hard_sync_req = 1'b1;
    @(negedge clk); hard_sync_req = 1'b0;
    step_to(h + 38); init_mode = 1'b1;
    step_to(h + 45);

    // reserved bit reads zero; 6/4 quanta, jump width 2, divide by 1
    cfg_en = 1'b1; cfg_write(16'hB540);
    chk(cfg_rdata == 16'h3540, "R1", "reserved bit masked", cfg_rdata, 16'h3540);
    cfg_en = 1'b0;
    @(negedge clk); init_mode = 1'b0;
    repeat (3) @(negedge clk);

    // start from waiting state by a falling edge, then resync cases
    h = cyc + 1;
    rx = 1'b0;
    want_sample(h + 6, 1'b1, "R7");  want_tx(h + 10, "R7");
    want_sample(h + 19, 1'b0, "R8"); want_tx(h + 23, "R10");
    want_sample(h + 30, 1'b1, "R4"); want_tx(h + 34, "R4");
    want_sample(h + 41, 1'b1, "R4"); want_tx(h + 43, "R9");
    want_sample(h + 50, 1'b0, "R9"); want_tx(h + 54, "R11");
    want_sample(h + 61, 1'b0, "R11"); want_tx(h + 65, "R4");
    step_to(h + 2);  rx = 1'b1;
    step_to(h + 13); rx = 1'b0;   // R8: error 3 limited to 2
    step_to(h + 14); rx = 1'b1;
    step_to(h + 15); rx = 1'b0;   // R10: second edge in same bit ignored
    step_to(h + 20); rx = 1'b1;
    step_to(h + 42); rx = 1'b0;   // R9: shortened to end at once
    step_to(h + 50); rx = 1'b1;
    step_to(h + 51); rx = 1'b0;   // R11: prior sample dominant, no resync
    step_to(h + 65); init_mode = 1'b1;
    step_to(h + 70);
    rx = 1'b1;

    // R5: phase-before field 0 acts as 1
    cfg_en = 1'b1; cfg_write(16'h0000);
    chk(cfg_rdata == 16'h0000, "R2", "accepted write", cfg_rdata, 0);
    cfg_en = 1'b0;
    @(negedge clk); init_mode = 1'b0;
    @(negedge clk);
    h = cyc + 1;
    hard_sync_req = 1'b1;
    want_sample(h + 2, 1'b1, "R5"); want_tx(h + 3, "R5");
    want_sample(h + 6, 1'b1, "R5"); want_tx(h + 7, "R5");
    @(negedge clk); hard_sync_req = 1'b0;
    step_to(h + 7); init_mode = 1'b1;
    step_to(h + 12);

    // R3: largest divider, 64 clocks per quantum
    cfg_en = 1'b1; cfg_write(16'h013F);
    cfg_en = 1'b0;
    @(negedge clk); init_mode = 1'b0;
    @(negedge clk);
    h = cyc + 1;
    hard_sync_req = 1'b1;
    want_sample(h + 128, 1'b1, "R3"); want_tx(h + 192, "R3");
    @(negedge clk); hard_sync_req = 1'b0;
    step_to(h + 192); init_mode = 1'b1;
    step_to(h + 200);

    // R12: requests and edges ignored in init
    p0 = pulses;
    hard_sync_req = 1'b1; rx = 1'b0;
    repeat (2) @(negedge clk);
    hard_sync_req = 1'b0; rx = 1'b1;
    repeat (300) @(negedge clk);
    chk(pulses == p0, "R12", "strobes during init", pulses, p0);

    chk(exp_s.size() == 0, "R13", "missing sample strobes", exp_s.size(), 0);
    chk(exp_t.size() == 0, "R13", "missing tx strobes", exp_t.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule